// File: doc/BRIEF.md
# Supply-Monitor Reset Pulse Generator

This block sequences the processor reset for a supply supervisor. It takes four digital inputs from elsewhere: a synchronised low-supply flag from an analog comparator, a one-cycle watchdog-fault request, a flag that says the backup battery is feeding the system, and a one-cycle timebase tick. The analog comparators, the oscillator and the battery switch are outside the block.

Reset is driven low for as long as the supply is bad. Once the supply recovers, reset stays low for a fixed number of timebase ticks and only then releases. A supply dip during that hold-off throws the partial count away. The same hold-off length is reused to form one reset pulse for each watchdog fault. A low-line status output follows the supply condition with no delay. A gated chip-enable output passes the processor's memory enable through only while the supply is good and the battery is not in use. This keeps writes from reaching battery-backed memory during brownouts.

The controller has three states. POWER_LOW means the supply is bad. HOLD means the hold-off ticks are being counted. RUN means reset is released. The transitions are:
- POWER_LOW to HOLD when the supply becomes good.
- HOLD to POWER_LOW, or RUN to POWER_LOW, when the supply goes bad.
- HOLD to RUN when the last hold-off tick arrives.
- RUN to HOLD when a watchdog fault arrives.

The hold-off length is chosen at build time from a short and a long tick count. The defaults are 512 and 2048 ticks.

Top module: `supv_reset_seq`

## Requirements
- R1: While `supply_low` is 1, `rst_out_n` is 0 in the same cycle, with no upper limit on the time.
- R2: After `supply_low` and `on_battery` both go to 0, `rst_out_n` stays 0 until the controller has seen HOLD_TICKS cycles with `tick` = 1. It rises in the cycle after the clock edge that samples the last of those ticks. HOLD_TICKS is LONG_TICKS when LONG_HOLD = 1, and SHORT_TICKS otherwise.
- R3: A supply dip during the hold-off drops reset at once. The next recovery then needs a full HOLD_TICKS ticks counted from zero.
- R4: A `wdog_fault` pulse while reset is released and the supply is good drives `rst_out_n` to 0 from the next cycle. It stays 0 for exactly HOLD_TICKS ticks.
- R5: `rst_out` is always the inverse of `rst_out_n`.
- R6: `low_line_n` is 0 in the same cycle that the supply is bad. It returns to 1 as soon as the supply is good, without waiting for the hold-off.
- R7: With the supply good and the battery not in use, `ce_out_n` equals `ce_in_n`. Otherwise `ce_out_n` is 1, whatever `ce_in_n` is.
- R8: While `on_battery` is 1, the outputs are `rst_out_n` 0, `rst_out` 1, `low_line_n` 0 and `ce_out_n` 1.
- R9: While `rst_n` is 0, the controller is in POWER_LOW with the hold-off count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_low | input | 1 | Synchronised low-supply flag from the comparator |
| on_battery | input | 1 | Backup battery is supplying the system |
| tick | input | 1 | One-cycle timebase tick |
| wdog_fault | input | 1 | One-cycle watchdog-fault request |
| ce_in_n | input | 1 | Memory chip-enable from the processor, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| low_line_n | output | 1 | Low-supply status, active low |
| ce_out_n | output | 1 | Gated memory chip-enable, active low |

## Verification
The bench runs two copies of the block side by side, one with the short hold-off and one with the long hold-off. It checks, at every tick, that each copy releases reset on its own final tick and not one tick earlier or later. A counter that is off by one would release a tick too soon or too late.

The bench also sweeps a supply dip across every tick position of the long hold-off. A design that kept its partial count would then release reset before a full hold-off had passed. Watchdog pulses are checked for length and timing in the same way.

Battery mode is exercised with the supply flag still good. A design that gated only on the supply comparator would leave low-line high and let the chip-enable through.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_POWER_LOW = 2'd0,
        ST_HOLD      = 2'd1,
        ST_RUN       = 2'd2
    } supv_state_t;
endpackage

// File: rtl/supv_hold_counter.sv
module supv_hold_counter #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic at_last
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (adv)
            count_q <= count_q + 1'b1;
    end

    assign at_last = (count_q == LAST);

    // R2: the hold-off count never runs past the final tick
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);

    // R9: the count is zero straight after block reset
    assert_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count_q == '0));
endmodule

// File: rtl/supv_reset_fsm.sv
module supv_reset_fsm
    import supv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic power_bad,
    input  logic wdog_fault,
    input  logic tick,
    input  logic at_last,
    output logic cnt_adv,
    output logic cnt_clr,
    output logic released
);
    supv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_LOW: if (!power_bad) state_d = ST_HOLD;
            ST_HOLD: begin
                if (power_bad)
                    state_d = ST_POWER_LOW;
                else if (tick && at_last)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (power_bad)
                    state_d = ST_POWER_LOW;
                else if (wdog_fault)
                    state_d = ST_HOLD;
            end
            default: state_d = ST_POWER_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_POWER_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        cnt_adv  = (state_q == ST_HOLD) && tick && !power_bad;
        cnt_clr  = (state_q != ST_HOLD) || power_bad || (tick && at_last);
        released = (state_q == ST_RUN);
    end

    // R3: any bad-supply cycle sends the controller back to POWER_LOW
    assert_dip_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        power_bad |=> (state_q == ST_POWER_LOW));

    // R2: the last tick in HOLD releases reset
    assert_release_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !power_bad && tick && at_last) |=> (state_q == ST_RUN));

    // R2: release only ever follows a sampled tick
    assert_release_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(tick));

    // R4: a watchdog fault in RUN starts a fresh hold-off
    assert_wdog_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !power_bad && wdog_fault) |=> (state_q == ST_HOLD && !at_last));
endmodule

// File: rtl/supv_ce_gate.sv
module supv_ce_gate (
    input  logic power_bad,
    input  logic ce_in_n,
    output logic ce_out_n
);
    always_comb begin
        ce_out_n = power_bad ? 1'b1 : ce_in_n;
    end
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
    parameter int SHORT_TICKS = 512,
    parameter int LONG_TICKS  = 2048,
    parameter bit LONG_HOLD   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic on_battery,
    input  logic tick,
    input  logic wdog_fault,
    input  logic ce_in_n,
    output logic rst_out_n,
    output logic rst_out,
    output logic low_line_n,
    output logic ce_out_n
);
    localparam int HOLD_TICKS = LONG_HOLD ? LONG_TICKS : SHORT_TICKS;

    logic power_bad;
    logic cnt_adv, cnt_clr, at_last, released;

    assign power_bad = supply_low | on_battery;

    supv_hold_counter #(.LIMIT(HOLD_TICKS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .adv     (cnt_adv),
        .at_last (at_last)
    );

    supv_reset_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_bad  (power_bad),
        .wdog_fault (wdog_fault),
        .tick       (tick),
        .at_last    (at_last),
        .cnt_adv    (cnt_adv),
        .cnt_clr    (cnt_clr),
        .released   (released)
    );

    supv_ce_gate u_ce (
        .power_bad (power_bad),
        .ce_in_n   (ce_in_n),
        .ce_out_n  (ce_out_n)
    );

    assign rst_out_n  = released & ~power_bad;
    assign rst_out    = ~rst_out_n;
    assign low_line_n = ~power_bad;

    // R1: reset is low on any clock edge that sees the supply low
    assert_reset_when_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !released);
endmodule

// File: tb/supv_reset_seq_test.sv
`timescale 1ns/1ps
module supv_reset_seq_test;
    localparam int NS = 4;
    localparam int NL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b1;
    logic on_battery = 1'b0;
    logic tick = 1'b0;
    logic wdog_fault = 1'b0;
    logic ce_in_n = 1'b0;
    logic l_rst_n, l_rst, l_low_n, l_ce_n;
    logic s_rst_n, s_rst, s_low_n, s_ce_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supv_reset_seq #(.SHORT_TICKS(NS), .LONG_TICKS(NL), .LONG_HOLD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .on_battery(on_battery),
        .tick(tick), .wdog_fault(wdog_fault), .ce_in_n(ce_in_n),
        .rst_out_n(l_rst_n), .rst_out(l_rst), .low_line_n(l_low_n), .ce_out_n(l_ce_n)
    );

    supv_reset_seq #(.SHORT_TICKS(NS), .LONG_TICKS(NL), .LONG_HOLD(1'b0)) uut_short (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .on_battery(on_battery),
        .tick(tick), .wdog_fault(wdog_fault), .ce_in_n(ce_in_n),
        .rst_out_n(s_rst_n), .rst_out(s_rst), .low_line_n(s_low_n), .ce_out_n(s_ce_n)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // R5: complement pins, checked wherever reset is checked
    task automatic chk_pair(input logic exp_l, input logic exp_s, input string req);
        chk(l_rst_n, exp_l, req);
        chk(s_rst_n, exp_s, req);
        chk(l_rst, ~exp_l, "R5 long complement");
        chk(s_rst, ~exp_s, "R5 short complement");
    endtask

    // Called just after the edge that entered HOLD; checks at t ticks for t = 0..maxt
    task automatic count_ticks(input int maxt, input string req);
        for (int t = 0; t <= maxt; t++) begin
            @(negedge clk);
            chk_pair(t >= NL, t >= NS, req);
            chk(l_low_n, 1'b1, "R6 low-line released during hold-off");
            if (t < maxt) begin
                tick = 1'b1;
                @(posedge clk);
                @(negedge clk);
                tick = 1'b0;
                @(posedge clk);
            end
        end
    endtask

    task automatic recover(input int maxt, input string req);
        @(negedge clk);
        supply_low = 1'b0;
        on_battery = 1'b0;
        #1;
        chk(l_low_n, 1'b1, "R6 low-line rises at once");
        chk_pair(1'b0, 1'b0, "R2 reset held at recovery");
        @(posedge clk);
        count_ticks(maxt, req);
    endtask

    task automatic dip;
        @(negedge clk);
        supply_low = 1'b1;
        #1;
        chk_pair(1'b0, 1'b0, "R1 reset low during dip");
        chk(l_low_n, 1'b0, "R6 low-line falls at once");
        chk(l_ce_n, 1'b1, "R7 chip-enable blocked in dip");
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state during block reset
        chk_pair(1'b0, 1'b0, "R9 reset state");
        chk(l_low_n, 1'b0, "R9 low-line in reset state");
        chk(s_ce_n, 1'b1, "R9 chip-enable in reset state");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: long bad supply keeps reset low
        repeat (20) begin
            tick = 1'b1;
            @(negedge clk);
            chk_pair(1'b0, 1'b0, "R1 reset while supply low");
        end
        tick = 1'b0;
        @(posedge clk);
        // R2: full power-up hold-off for both variants
        recover(NL, "R2 hold-off length");
        // R7: pass-through with the supply good
        @(negedge clk);
        ce_in_n = 1'b0;
        #1 chk(l_ce_n, 1'b0, "R7 pass-through low");
        ce_in_n = 1'b1;
        #1 chk(s_ce_n, 1'b1, "R7 pass-through high");
        ce_in_n = 1'b0;
        // R4: watchdog pulses, twice
        repeat (2) begin
            @(negedge clk);
            wdog_fault = 1'b1;
            #1 chk_pair(1'b1, 1'b1, "R4 reset released before fault edge");
            @(posedge clk);
            #1 wdog_fault = 1'b0;
            count_ticks(NL, "R4 watchdog pulse length");
        end
        // R3: a dip at every tick position of the long hold-off
        for (int k = 0; k <= NL; k++) begin
            dip();
            recover(k, "R3 partial hold-off");
            dip();
            recover(NL, "R3 hold-off restarts from zero");
        end
        // R8: battery mode with the comparator still good
        @(negedge clk);
        ce_in_n = 1'b0;
        on_battery = 1'b1;
        #1;
        chk_pair(1'b0, 1'b0, "R8 reset in battery mode");
        chk(l_low_n, 1'b0, "R8 low-line in battery mode");
        chk(l_ce_n, 1'b1, "R8 chip-enable blocked in battery mode");
        chk(s_ce_n, 1'b1, "R7 chip-enable blocked in battery mode");
        repeat (5) begin
            tick = 1'b1;
            @(negedge clk);
            chk_pair(1'b0, 1'b0, "R8 reset stays low on battery");
        end
        tick = 1'b0;
        @(posedge clk);
        recover(NL, "R2 hold-off after battery");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule